// File: doc/BRIEF.md
# Atomic Compare-and-Swap Word Memory

This block is a small word-addressed memory shared by several requester ports. Besides ordinary reads and writes, each port can ask for an atomic compare-and-swap in four forms. The single form works on one word. The wide form works on an even/odd word pair. The split form compares one word and writes two. The tagged form keeps an index and a version count in one word. Each request reports a success flag and the content read before any update, so a requester can tell a lost race from a win and retry on its own.

A round-robin arbiter lets one request reach the storage in each cycle. The read, the comparison and the write of the granted request all take place in that single slot. No other port, including one doing a plain write, can act between the comparison and the update. A granted request is answered in the cycle it is granted, and the memory changes at the next clock edge. A port that is not granted keeps its request unchanged until its response pulse appears.

Top module: `cas_mem_unit`

## Requirements
- R1: Op code 2 (single compare-and-swap) compares word `addr` with `cmp_lo`. When they are equal it writes `new_lo` and reports ok=1. In every case `resp_old_lo` is the word as it was before the request.
- R2: A compare that fails writes nothing and reports ok=0. `resp_old_lo` then shows the current content, including a value another port stored since the requester last read it.
- R3: Op code 3 (wide) needs an even address. It reports ok=1 only if word `addr` equals `cmp_lo` and word `addr+1` equals `cmp_hi`, and then it writes `new_lo` and `new_hi` to the two words. `resp_old_hi` reports the prior odd word.
- R4: Op code 4 (split) needs an even address. It compares only word `addr` against `cmp_lo`. On a match it writes `new_lo` to `addr` and `new_hi` to `addr+1`. `cmp_hi` is ignored.
- R5: Op code 5 (tagged) treats bits [15:0] as an index and bits [31:16] as a version count. The whole word is compared with `cmp_lo`. On success the word becomes {old count + 1, `new_lo[15:0]`}, with the count wrapping from 0xFFFF to 0 and no flag. Upper bits of `new_lo` are ignored.
- R6: Op code 0 (read) returns the word with ok=1 and changes nothing. Op code 1 (write) stores `new_lo`, returns the prior word and reports ok=1. Single-word ops report `resp_old_hi` = 0.
- R7: At most one `resp_valid` bit is high in a cycle. It goes high only for a port that is requesting, in the same cycle as the grant. After port i is served, the search for the next grant begins at port i+1 and wraps around.
- R8: A wide or split request at an odd address, and the unused op codes 6 and 7, report err=1 and ok=0 and write nothing.
- R9: When several ports present a compare-and-swap against the same old value in the same cycle, exactly one of them succeeds. The others see the winner's value in `resp_old_lo`.
- R10: Reset clears every word to zero and gives port 0 first priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NP | Request present, one bit per port |
| req_op | input | NP×3 | Operation code per port |
| req_addr | input | NP×AW | Word address per port |
| req_cmp_lo | input | NP×DW | Expected value for the first word |
| req_cmp_hi | input | NP×DW | Expected value for the second word |
| req_new_lo | input | NP×DW | Replacement value for the first word |
| req_new_hi | input | NP×DW | Replacement value for the second word |
| resp_valid | output | NP | One-cycle response pulse for the granted port |
| resp_ok | output | 1 | Substitution performed (or plain op accepted) |
| resp_err | output | 1 | Misaligned pair request or unused op code |
| resp_old_lo | output | DW | First word before the request |
| resp_old_hi | output | DW | Second word before the request (pair ops) |

## Verification
The hardest case to reach is a true race. Two or more ports must hit the same word with the same expected value in the same cycle, so that the arbiter alone decides the winner and the loser's compare runs against a value stored one edge earlier. The bench raises all three requests at one falling edge after a reset, so priority begins at port 0. It then keeps the losers asserted cycle after cycle and checks each grant pulse together with the old value it returns. A second burst, started after a lone request from port 1, shows that the search for the next grant begins at port 2.

// File: rtl/cas_pkg.sv
package cas_pkg;
  typedef enum logic [2:0] {
    OP_RD    = 3'd0,
    OP_WR    = 3'd1,
    OP_CAS   = 3'd2,
    OP_WIDE  = 3'd3,
    OP_SPLIT = 3'd4,
    OP_TAG   = 3'd5
  } cas_op_e;

  // Operations that touch an even/odd word pair.
  function automatic logic op_is_pair(logic [2:0] op);
    return (op == OP_WIDE) || (op == OP_SPLIT);
  endfunction
endpackage

// File: rtl/cas_rr_arbiter.sv
module cas_rr_arbiter #(
  parameter int NP = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] req,
  output logic [NP-1:0] gnt
);
  localparam int IW = (NP > 1) ? $clog2(NP) : 1;

  logic [IW-1:0] last_q;
  logic [IW-1:0] win_idx;
  logic          found;

  always_comb begin
    gnt     = '0;
    win_idx = last_q;
    found   = 1'b0;
    for (int k = 1; k <= NP; k++) begin
      int idx;
      idx = (int'(last_q) + k) % NP;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        win_idx  = IW'(idx);
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     last_q <= IW'(NP - 1);
    else if (found) last_q <= win_idx;
  end
endmodule

// File: rtl/cas_exec.sv
module cas_exec
  import cas_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic [2:0]    op,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] cmp_lo,
  input  logic [DW-1:0] cmp_hi,
  input  logic [DW-1:0] new_lo,
  input  logic [DW-1:0] new_hi,
  input  logic [DW-1:0] rd_lo,
  input  logic [DW-1:0] rd_hi,
  output logic          ok,
  output logic          err,
  output logic          we_lo,
  output logic          we_hi,
  output logic [DW-1:0] wd_lo,
  output logic [DW-1:0] wd_hi,
  output logic [DW-1:0] old_lo,
  output logic [DW-1:0] old_hi
);
  localparam int HW = DW / 2;

  // Tagged word: upper half counts versions, lower half holds the index.
  function automatic logic [DW-1:0] tag_word(logic [DW-1:0] cur, logic [DW-1:0] nv);
    logic [HW-1:0] ver;
    ver = cur[DW-1:HW] + 1'b1;
    return {ver, nv[HW-1:0]};
  endfunction

  logic aligned;
  logic lo_hit, hi_hit;

  assign aligned = ~addr[0];
  assign lo_hit  = (rd_lo == cmp_lo);
  assign hi_hit  = (rd_hi == cmp_hi);

  always_comb begin
    ok     = 1'b0;
    err    = 1'b0;
    we_lo  = 1'b0;
    we_hi  = 1'b0;
    wd_lo  = new_lo;
    wd_hi  = new_hi;
    old_lo = rd_lo;
    old_hi = op_is_pair(op) ? rd_hi : '0;
    case (cas_op_e'(op))
      OP_RD:  ok = 1'b1;
      OP_WR: begin
        ok    = 1'b1;
        we_lo = 1'b1;
      end
      OP_CAS: begin
        ok    = lo_hit;
        we_lo = lo_hit;
      end
      OP_WIDE: begin
        if (!aligned) err = 1'b1;
        else begin
          ok    = lo_hit && hi_hit;
          we_lo = lo_hit && hi_hit;
          we_hi = lo_hit && hi_hit;
        end
      end
      OP_SPLIT: begin
        if (!aligned) err = 1'b1;
        else begin
          ok    = lo_hit;
          we_lo = lo_hit;
          we_hi = lo_hit;
        end
      end
      OP_TAG: begin
        ok    = lo_hit;
        we_lo = lo_hit;
        wd_lo = tag_word(rd_lo, new_lo);
      end
      default: err = 1'b1;
    endcase
  end
endmodule

// File: rtl/cas_store.sv
module cas_store #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we_lo,
  input  logic          we_hi,
  input  logic [DW-1:0] wd_lo,
  input  logic [DW-1:0] wd_hi,
  output logic [DW-1:0] rd_lo,
  output logic [DW-1:0] rd_hi
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] addr_odd;

  assign addr_odd = {addr[AW-1:1], 1'b1};
  assign rd_lo    = mem[addr];
  assign rd_hi    = mem[addr_odd];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (we_lo) mem[addr]     <= wd_lo;
      if (we_hi) mem[addr_odd] <= wd_hi;
    end
  end
endmodule

// File: rtl/cas_mem_unit.sv
module cas_mem_unit #(
  parameter int NP = 3,
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NP-1:0]          req_valid,
  input  logic [NP-1:0][2:0]     req_op,
  input  logic [NP-1:0][AW-1:0]  req_addr,
  input  logic [NP-1:0][DW-1:0]  req_cmp_lo,
  input  logic [NP-1:0][DW-1:0]  req_cmp_hi,
  input  logic [NP-1:0][DW-1:0]  req_new_lo,
  input  logic [NP-1:0][DW-1:0]  req_new_hi,
  output logic [NP-1:0]          resp_valid,
  output logic                   resp_ok,
  output logic                   resp_err,
  output logic [DW-1:0]          resp_old_lo,
  output logic [DW-1:0]          resp_old_hi
);
  logic [NP-1:0] gnt;
  logic          any_gnt;

  logic [2:0]    s_op;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_cmp_lo, s_cmp_hi, s_new_lo, s_new_hi;

  logic [DW-1:0] rd_lo, rd_hi, wd_lo, wd_hi;
  logic          ex_ok, ex_err, ex_we_lo, ex_we_hi;
  logic          st_we_lo, st_we_hi;

  cas_rr_arbiter #(.NP(NP)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req_valid),
    .gnt   (gnt)
  );

  assign any_gnt = |gnt;

  always_comb begin
    s_op     = '0;
    s_addr   = '0;
    s_cmp_lo = '0;
    s_cmp_hi = '0;
    s_new_lo = '0;
    s_new_hi = '0;
    for (int i = 0; i < NP; i++) begin
      if (gnt[i]) begin
        s_op     = req_op[i];
        s_addr   = req_addr[i];
        s_cmp_lo = req_cmp_lo[i];
        s_cmp_hi = req_cmp_hi[i];
        s_new_lo = req_new_lo[i];
        s_new_hi = req_new_hi[i];
      end
    end
  end

  cas_exec #(.DW(DW), .AW(AW)) u_exec (
    .op     (s_op),
    .addr   (s_addr),
    .cmp_lo (s_cmp_lo),
    .cmp_hi (s_cmp_hi),
    .new_lo (s_new_lo),
    .new_hi (s_new_hi),
    .rd_lo  (rd_lo),
    .rd_hi  (rd_hi),
    .ok     (ex_ok),
    .err    (ex_err),
    .we_lo  (ex_we_lo),
    .we_hi  (ex_we_hi),
    .wd_lo  (wd_lo),
    .wd_hi  (wd_hi),
    .old_lo (resp_old_lo),
    .old_hi (resp_old_hi)
  );

  assign st_we_lo = any_gnt && ex_we_lo;
  assign st_we_hi = any_gnt && ex_we_hi;

  cas_store #(.DW(DW), .AW(AW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (s_addr),
    .we_lo (st_we_lo),
    .we_hi (st_we_hi),
    .wd_lo (wd_lo),
    .wd_hi (wd_hi),
    .rd_lo (rd_lo),
    .rd_hi (rd_hi)
  );

  assign resp_valid = gnt;
  assign resp_ok    = any_gnt && ex_ok;
  assign resp_err   = any_gnt && ex_err;
endmodule

// File: rtl/cas_mem_checks.sv
module cas_mem_checks #(
  parameter int NP = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NP-1:0] req_valid,
  input logic [NP-1:0] resp_valid,
  input logic          resp_ok,
  input logic          resp_err,
  input logic          st_we_lo,
  input logic          st_we_hi
);
  p_single_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(resp_valid));

  p_resp_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid & ~req_valid) == '0);

  p_idle_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid == '0) |-> !(st_we_lo || st_we_hi));

  p_fail_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((resp_valid != '0) && !resp_ok) |-> !(st_we_lo || st_we_hi));

  p_err_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> (!resp_ok && !st_we_lo && !st_we_hi));

  for (genvar i = 0; i < NP; i++) begin : g_rr
    p_rr_no_repeat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid[i] && ((req_valid & ~resp_valid) != '0)) |=> !resp_valid[i]);
  end
endmodule

bind cas_mem_unit cas_mem_checks #(.NP(NP)) u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .resp_valid (resp_valid),
  .resp_ok    (resp_ok),
  .resp_err   (resp_err),
  .st_we_lo   (st_we_lo),
  .st_we_hi   (st_we_hi)
);

// File: tb/test_cas_mem_unit.sv
module test_cas_mem_unit;
  localparam int NP = 3;
  localparam int DW = 32;
  localparam int AW = 4;

  typedef struct packed {
    logic [3:0]  rq;
    logic [2:0]  op;
    logic [3:0]  addr;
    logic [31:0] cl, ch, nl, nh;
    logic        ok, err;
    logic [31:0] ol, oh;
  } vec_t;

  localparam int NV = 28;
  // Port 0 alone, memory cleared by reset; op: 0 rd,1 wr,2 cas,3 wide,4 split,5 tag
  localparam vec_t VT[NV] = '{
    '{4'd10, 3'd0, 4'd0, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0, 32'h0, 32'h0},                 // R10
    '{4'd6,  3'd1, 4'd0, 32'h0, 32'h0, 32'h11, 32'h0, 1'b1, 1'b0, 32'h0, 32'h0},                // R6
    '{4'd6,  3'd0, 4'd0, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0, 32'h11, 32'h0},                // R6
    '{4'd1,  3'd2, 4'd0, 32'h11, 32'h0, 32'h22, 32'h0, 1'b1, 1'b0, 32'h11, 32'h0},              // R1
    '{4'd2,  3'd2, 4'd0, 32'h11, 32'h0, 32'h33, 32'h0, 1'b0, 1'b0, 32'h22, 32'h0},              // R2
    '{4'd2,  3'd0, 4'd0, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0, 32'h22, 32'h0},                // R2
    '{4'd6,  3'd1, 4'd2, 32'h0, 32'h0, 32'hA, 32'h0, 1'b1, 1'b0, 32'h0, 32'h0},                 // R6
    '{4'd6,  3'd1, 4'd3, 32'h0, 32'h0, 32'hB, 32'h0, 1'b1, 1'b0, 32'h0, 32'h0},                 // R6
    '{4'd3,  3'd3, 4'd2, 32'hA, 32'hB, 32'hC, 32'hD, 1'b1, 1'b0, 32'hA, 32'hB},                 // R3
    '{4'd3,  3'd3, 4'd2, 32'hC, 32'hB, 32'h1, 32'h2, 1'b0, 1'b0, 32'hC, 32'hD},                 // R3
    '{4'd8,  3'd3, 4'd3, 32'hD, 32'hD, 32'hE, 32'hF, 1'b0, 1'b1, 32'hD, 32'hD},                 // R8
    '{4'd3,  3'd0, 4'd2, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0, 32'hC, 32'h0},                 // R3
    '{4'd8,  3'd0, 4'd3, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0, 32'hD, 32'h0},                 // R8
    '{4'd4,  3'd4, 4'd4, 32'h0, 32'h77, 32'h5, 32'h6, 1'b1, 1'b0, 32'h0, 32'h0},                // R4
    '{4'd4,  3'd0, 4'd5, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0, 32'h6, 32'h0},                 // R4
    '{4'd4,  3'd4, 4'd4, 32'h0, 32'h6, 32'h8, 32'h9, 1'b0, 1'b0, 32'h5, 32'h6},                 // R4
    '{4'd5,  3'd5, 4'd6, 32'h0, 32'h0, 32'h7, 32'h0, 1'b1, 1'b0, 32'h0, 32'h0},                 // R5
    '{4'd5,  3'd5, 4'd6, 32'h0001_0007, 32'h0, 32'hAAAA_0009, 32'h0, 1'b1, 1'b0, 32'h0001_0007, 32'h0}, // R5
    '{4'd5,  3'd5, 4'd6, 32'h0001_0007, 32'h0, 32'h1, 32'h0, 1'b0, 1'b0, 32'h0002_0009, 32'h0}, // R5
    '{4'd5,  3'd0, 4'd6, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0, 32'h0002_0009, 32'h0},         // R5
    '{4'd6,  3'd1, 4'd7, 32'h0, 32'h0, 32'hFFFF_0003, 32'h0, 1'b1, 1'b0, 32'h0, 32'h0},         // R6
    '{4'd5,  3'd5, 4'd7, 32'hFFFF_0003, 32'h0, 32'h3, 32'h0, 1'b1, 1'b0, 32'hFFFF_0003, 32'h0}, // R5 wrap
    '{4'd5,  3'd0, 4'd7, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0, 32'h3, 32'h0},                 // R5
    '{4'd8,  3'd6, 4'd8, 32'h0, 32'h0, 32'h55, 32'h0, 1'b0, 1'b1, 32'h0, 32'h0},                // R8
    '{4'd8,  3'd0, 4'd8, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0, 32'h0, 32'h0},                 // R8
    '{4'd8,  3'd4, 4'd9, 32'h0, 32'h0, 32'h66, 32'h77, 1'b0, 1'b1, 32'h0, 32'h0},               // R8
    '{4'd8,  3'd0, 4'd9, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0, 32'h0, 32'h0},                 // R8
    '{4'd8,  3'd7, 4'd10, 32'h0, 32'h0, 32'h1, 32'h0, 1'b0, 1'b1, 32'h0, 32'h0}                 // R8
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]         req_valid = '0;
  logic [NP-1:0][2:0]    req_op = '0;
  logic [NP-1:0][AW-1:0] req_addr = '0;
  logic [NP-1:0][DW-1:0] req_cmp_lo = '0, req_cmp_hi = '0, req_new_lo = '0, req_new_hi = '0;
  logic [NP-1:0]         resp_valid;
  logic                  resp_ok, resp_err;
  logic [DW-1:0]         resp_old_lo, resp_old_hi;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cas_mem_unit #(.NP(NP), .DW(DW), .AW(AW)) i_cas_mem_unit (
    .clk, .rst_n, .req_valid, .req_op, .req_addr, .req_cmp_lo, .req_cmp_hi,
    .req_new_lo, .req_new_hi, .resp_valid, .resp_ok, .resp_err, .resp_old_lo, .resp_old_hi
  );

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic set_port(int p, logic [2:0] op, logic [3:0] a, logic [31:0] cl,
                          logic [31:0] ch, logic [31:0] nl, logic [31:0] nh);
    req_op[p] = op; req_addr[p] = a;
    req_cmp_lo[p] = cl; req_cmp_hi[p] = ch; req_new_lo[p] = nl; req_new_hi[p] = nh;
    req_valid[p] = 1'b1;
  endtask

  task automatic do_reset();
    req_valid = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1 chk("R10", "idle resp_valid", 32'(resp_valid), 32'h0);

    for (int v = 0; v < NV; v++) begin
      string rq;
      rq = $sformatf("R%0d vec%0d", VT[v].rq, v);
      @(negedge clk);
      set_port(0, VT[v].op, VT[v].addr, VT[v].cl, VT[v].ch, VT[v].nl, VT[v].nh);
      #1;
      chk(rq, "valid", 32'(resp_valid), 32'h1);
      chk(rq, "ok", 32'(resp_ok), 32'(VT[v].ok));
      chk(rq, "err", 32'(resp_err), 32'(VT[v].err));
      chk(rq, "old_lo", resp_old_lo, VT[v].ol);
      chk(rq, "old_hi", resp_old_hi, VT[v].oh);
      @(negedge clk);
      req_valid = '0;
    end

    // R10: reset mid-run clears storage
    do_reset();
    set_port(0, 3'd0, 4'd7, 0, 0, 0, 0);
    #1 chk("R10", "word7 after reset", resp_old_lo, 32'h0);
    @(negedge clk); req_valid = '0;
    do_reset();

    // R9 race: all ports CAS word 11 expecting 0, port p offers p+1; R10 port 0 first
    @(negedge clk);
    for (int p = 0; p < NP; p++) set_port(p, 3'd2, 4'd11, 32'h0, 32'h0, 32'(p + 1), 32'h0);
    #1;
    chk("R9", "race grant0", 32'(resp_valid), 32'h1);
    chk("R9", "race ok0", 32'(resp_ok), 32'h1);
    @(negedge clk); req_valid[0] = 1'b0;
    #1;
    chk("R7", "race grant1", 32'(resp_valid), 32'h2);
    chk("R9", "race ok1", 32'(resp_ok), 32'h0);
    chk("R9", "race old1", resp_old_lo, 32'h1);
    @(negedge clk); req_valid[1] = 1'b0;
    #1;
    chk("R7", "race grant2", 32'(resp_valid), 32'h4);
    chk("R9", "race ok2", 32'(resp_ok), 32'h0);
    chk("R9", "race old2", resp_old_lo, 32'h1);
    @(negedge clk); req_valid = '0;
    set_port(2, 3'd0, 4'd11, 0, 0, 0, 0);
    #1 chk("R9", "final word11", resp_old_lo, 32'h1);
    @(negedge clk); req_valid = '0;

    // R7 rotation: lone port 1, then all three -> order 2, 0, 1
    set_port(1, 3'd0, 4'd0, 0, 0, 0, 0);
    #1 chk("R7", "lone p1", 32'(resp_valid), 32'h2);
    @(negedge clk); req_valid = '0;
    for (int p = 0; p < NP; p++) set_port(p, 3'd0, 4'd11, 0, 0, 0, 0);
    #1 chk("R7", "rr first", 32'(resp_valid), 32'h4);
    @(negedge clk); req_valid[2] = 1'b0;
    #1 chk("R7", "rr second", 32'(resp_valid), 32'h1);
    @(negedge clk); req_valid[0] = 1'b0;
    #1 chk("R7", "rr third", 32'(resp_valid), 32'h2);
    @(negedge clk); req_valid = '0;
    #1 chk("R7", "rr idle", 32'(resp_valid), 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule